// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

A combinational 16-bit arithmetic and logic unit for a small microcontroller datapath. It takes a source operand, a destination operand, the current carry flag, a 4-bit operation code and a byte/word size bit. It returns the result, a write-enable for the destination, a flag-update enable and new values for the carry (C), zero (Z), negative (N) and overflow (V) flags.

Subtraction is performed as the destination plus the inverted source plus a carry-in, so C reads as "no borrow". Logical operations report C as the inverse of Z. Some operations leave the status register alone, and the block says so with its flag-update enable. Everything the size bit touches, including carry and overflow, is taken at bit 7 in byte mode and at bit 15 in word mode.

Top module: `alu16`

## Requirements
- R1: Code 0 gives dst+src, and code 1 gives dst+src+carry_i. C is the carry out of the operand's top bit.
- R2: Codes 2 and 4 give dst+~src+1, and code 3 gives dst+~src+carry_i. C=1 means no borrow. Code 4 drives the same result and flags with wr_o=0.
- R3: For codes 0 and 1, V=1 when both operands have the same sign and the result has the other sign. For codes 2 to 4, V=1 when the operands differ in sign and the result has the source's sign.
- R4: Whenever flag_o=1, Z=1 exactly when the size-masked result is zero, and N equals the result's top bit at the current size.
- R5: Code 6 (dst&src), code 7 (dst^src) and code 8 (a test of dst&src with wr_o=0) set C=~Z and V=0.
- R6: Code 9 (dst|src) and code 10 (dst&~src) write the result with flag_o=0. When flag_o=0, all four flag outputs are 0.
- R7: Code 5 adds dst, src and carry_i as packed BCD digits. C=1 when the true sum exceeds 9999 in word mode or 99 in byte mode. V=0.
- R8: Code 11 shifts dst right while keeping its sign bit. Code 12 shifts dst right with carry_i entering the top bit. For both, C takes the old bit 0 and V=0.
- R9: Code 13 copies dst bit 7 into bits 15..8 and sets C=~Z and V=0. Code 14 swaps the two bytes of dst with flag_o=0. Both codes ignore byte_i.
- R10: With byte_i=1, codes 0 to 12 use only the low bytes of the operands, force result bits 15..8 to 0, and take C, V, N and Z from 8-bit arithmetic.
- R11: Code 15 returns dst unchanged, with wr_o=0 and flag_o=0. Every other code has flag_o=1 unless R6 or R9 says otherwise, and wr_o=1 unless R2, R5 or R11 says otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte size, 0 selects word size |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Destination write-enable |
| flag_o | output | 1 | Flag-update enable |
| c_o | output | 1 | New carry |
| z_o | output | 1 | New zero |
| n_o | output | 1 | New negative |
| v_o | output | 1 | New overflow |

## Verification
The block holds no state, so every fault shows up at the outputs in the same cycle as the input pattern that exposes it. A wrong carry chain or a misplaced size tap usually shows as a flag mismatch while the result is still correct. That tends to happen at sign and carry boundaries in byte mode, and on BCD digits that need a +6 correction. The bench uses directed operand values at those boundaries and adds random patterns. It compares all seven outputs against a model written with integer arithmetic every cycle.

// File: rtl/alu16.sv
module alu16 (
  input  logic [15:0] src_i,
  input  logic [15:0] dst_i,
  input  logic        carry_i,
  input  logic [3:0]  op_i,
  input  logic        byte_i,
  output logic [15:0] res_o,
  output logic        wr_o,
  output logic        flag_o,
  output logic        c_o,
  output logic        z_o,
  output logic        n_o,
  output logic        v_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDC = 4'd1, OP_SUB = 4'd2, OP_SUBC = 4'd3,
                         OP_CMP = 4'd4, OP_DADD = 4'd5, OP_AND = 4'd6, OP_XOR = 4'd7,
                         OP_BIT = 4'd8, OP_BIS = 4'd9, OP_BIC = 4'd10, OP_RRA = 4'd11,
                         OP_RRC = 4'd12, OP_SXT = 4'd13, OP_SWPB = 4'd14;

  logic        is_sub, cin_sel, full, narrow;
  logic [15:0] opb, raw;
  logic [16:0] sum_w;
  logic [8:0]  sum_b;
  logic [15:0] bcd;
  logic [4:0]  dcar;
  logic [4:0]  dig;
  logic        arith, logic_c, c_raw, v_raw, am, bm, rm, zz, nn;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign opb    = is_sub ? ~src_i : src_i;
  assign cin_sel = (op_i == OP_SUB || op_i == OP_CMP) ? 1'b1 :
                   (op_i == OP_ADDC || op_i == OP_SUBC) ? carry_i : 1'b0;
  assign sum_w  = {1'b0, dst_i} + {1'b0, opb} + {16'd0, cin_sel};
  assign sum_b  = {1'b0, dst_i[7:0]} + {1'b0, opb[7:0]} + {8'd0, cin_sel};
  assign arith  = (op_i <= OP_CMP);
  assign full   = (op_i >= OP_SXT);
  assign narrow = byte_i && !full;

  always_comb begin
    dcar[0] = carry_i;
    bcd = '0;
    dig = '0;
    for (int k = 0; k < 4; k++) begin
      dig = {1'b0, dst_i[4*k +: 4]} + {1'b0, src_i[4*k +: 4]} + {4'd0, dcar[k]};
      dcar[k+1] = (dig > 5'd9);
      if (dig > 5'd9) dig = dig + 5'd6;
      bcd[4*k +: 4] = dig[3:0];
    end
  end

  always_comb begin
    raw = dst_i;
    c_raw = 1'b0;
    logic_c = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        raw = sum_w[15:0];
        c_raw = byte_i ? sum_b[8] : sum_w[16];
      end
      OP_DADD: begin
        raw = bcd;
        c_raw = byte_i ? dcar[2] : dcar[4];
      end
      OP_AND, OP_BIT: begin raw = dst_i & src_i; logic_c = 1'b1; end
      OP_XOR:  begin raw = dst_i ^ src_i; logic_c = 1'b1; end
      OP_BIS:  raw = dst_i | src_i;
      OP_BIC:  raw = dst_i & ~src_i;
      OP_RRA: begin
        raw = byte_i ? {8'h00, dst_i[7], dst_i[7:1]} : {dst_i[15], dst_i[15:1]};
        c_raw = dst_i[0];
      end
      OP_RRC: begin
        raw = byte_i ? {8'h00, carry_i, dst_i[7:1]} : {carry_i, dst_i[15:1]};
        c_raw = dst_i[0];
      end
      OP_SXT:  begin raw = {{8{dst_i[7]}}, dst_i[7:0]}; logic_c = 1'b1; end
      OP_SWPB: raw = {dst_i[7:0], dst_i[15:8]};
      default: raw = dst_i;
    endcase
  end

  assign res_o = narrow ? {8'h00, raw[7:0]} : raw;
  assign am    = byte_i ? dst_i[7] : dst_i[15];
  assign bm    = byte_i ? opb[7]   : opb[15];
  assign rm    = narrow ? res_o[7] : res_o[15];
  assign v_raw = arith && (am == bm) && (rm != am);
  assign zz    = (res_o == 16'd0);
  assign nn    = rm;

  assign wr_o   = !(op_i == OP_CMP || op_i == OP_BIT || op_i == 4'd15);
  assign flag_o = !(op_i == OP_BIS || op_i == OP_BIC || op_i == OP_SWPB || op_i == 4'd15);
  assign c_o    = flag_o && (logic_c ? !zz : c_raw);
  assign z_o    = flag_o && zz;
  assign n_o    = flag_o && nn;
  assign v_o    = flag_o && v_raw;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk (
  input logic [15:0] src_i,
  input logic [15:0] dst_i,
  input logic        carry_i,
  input logic [3:0]  op_i,
  input logic        byte_i,
  input logic [15:0] res_o,
  input logic        wr_o,
  input logic        flag_o,
  input logic        c_o,
  input logic        z_o,
  input logic        n_o,
  input logic        v_o
);
  always_comb begin
    // R10
    hi_byte_chk: assert (!(byte_i && op_i < 4'd13) || res_o[15:8] == 8'h00)
      else $error("high byte not cleared in byte mode");
    // R4
    zero_flag_chk: assert (!flag_o || z_o == (res_o == 16'd0))
      else $error("zero flag disagrees with result");
    // R5
    logic_c_chk: assert (!(op_i == 4'd6 || op_i == 4'd7 || op_i == 4'd8) || (c_o == !z_o && !v_o))
      else $error("logic op carry/overflow wrong");
    // R6
    quiet_flag_chk: assert (flag_o || !(c_o || z_o || n_o || v_o))
      else $error("flags driven while update disabled");
    // R7
    bcd_v_chk: assert (op_i != 4'd5 || !v_o)
      else $error("decimal add set overflow");
    // R11
    pass_chk: assert (op_i != 4'd15 || (res_o == dst_i && !wr_o && !flag_o))
      else $error("code 15 not a pass-through");
    // R2
    cmp_nowr_chk: assert (op_i != 4'd4 || !wr_o)
      else $error("compare requests a write");
  end
endmodule

bind alu16 alu16_chk u_alu16_chk (.*);

// File: tb/alu16_bench.sv
`timescale 1ns/1ps
module alu16_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] src_i, dst_i, res_o;
  logic        carry_i, byte_i, wr_o, flag_o, c_o, z_o, n_o, v_o;
  logic [3:0]  op_i;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  alu16 u_alu16 (.src_i(src_i), .dst_i(dst_i), .carry_i(carry_i), .op_i(op_i), .byte_i(byte_i),
                 .res_o(res_o), .wr_o(wr_o), .flag_o(flag_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o));

  function automatic int bcd2int(input int x, input int nd);
    int t = 0;
    int m = 1;
    for (int i = 0; i < nd; i++) begin t += ((x >> (4*i)) & 15) * m; m *= 10; end
    return t;
  endfunction

  function automatic int int2bcd(input int x, input int nd);
    int t = 0;
    for (int i = 0; i < nd; i++) begin t |= (x % 10) << (4*i); x /= 10; end
    return t;
  endfunction

  function automatic string tag(input int op, input bit bm);
    if (bm && op < 13) return "R10";
    case (op)
      0, 1: return "R1";
      2, 3, 4: return "R2";
      5: return "R7";
      6, 7, 8: return "R5";
      9, 10: return "R6";
      11, 12: return "R8";
      13, 14: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [15:0] s, input logic [15:0] d, input logic ci,
                     input int op, input logic bm);
    int W, mask, sgn, a, b, sum, r, lim, tot;
    bit w, f, c, z, n, v;
    @(posedge clk); #2;
    src_i = s; dst_i = d; carry_i = ci; op_i = op[3:0]; byte_i = bm;
    W = (bm && op < 13) ? 8 : 16;
    mask = (1 << W) - 1; sgn = 1 << (W - 1);
    a = int'(d) & mask; b = int'(s) & mask;
    r = 0; c = 0; v = 0; w = 1; f = 1; sum = 0;
    case (op)
      0, 1: begin // R1 R3
        sum = a + b + ((op == 1) ? int'(ci) : 0);
        r = sum & mask; c = ((sum >> W) & 1) != 0;
        v = ((a & sgn) == (b & sgn)) && ((r & sgn) != (a & sgn));
      end
      2, 3, 4: begin // R2 R3
        sum = a + ((~b) & mask) + ((op == 3) ? int'(ci) : 1);
        r = sum & mask; c = ((sum >> W) & 1) != 0;
        v = ((a & sgn) != (b & sgn)) && ((r & sgn) == (b & sgn));
        if (op == 4) w = 0;
      end
      5: begin // R7
        lim = (W == 8) ? 100 : 10000;
        tot = bcd2int(a, W/4) + bcd2int(b, W/4) + int'(ci);
        c = tot >= lim; r = int2bcd(tot % lim, W/4);
      end
      6, 8: begin r = a & b; if (op == 8) w = 0; end
      7: r = a ^ b;
      9: begin r = a | b; f = 0; end
      10: begin r = a & ~b & mask; f = 0; end
      11: begin r = (a >> 1) | (a & sgn); c = (a & 1) != 0; end
      12: begin r = (a >> 1) | (ci ? sgn : 0); c = (a & 1) != 0; end
      13: r = (d[7]) ? (int'(d) | 'hFF00) : (int'(d) & 'hFF);
      14: begin r = ((int'(d) & 'hFF) << 8) | (int'(d) >> 8); f = 0; end
      default: begin r = int'(d); w = 0; f = 0; end
    endcase
    z = (r == 0);
    n = (r & sgn) != 0;
    if (op >= 6 && op <= 8 || op == 13) c = !z;
    if (!f) begin c = 0; z = 0; n = 0; v = 0; end
    @(negedge clk);
    checks++;
    if (res_o !== r[15:0] || wr_o !== w || flag_o !== f || c_o !== c || z_o !== z || n_o !== n || v_o !== v) begin
      errors++;
      $display("FAIL %s op=%0d byte=%0b: got res=%h wr=%b fl=%b CZNV=%b%b%b%b expected res=%h wr=%b fl=%b CZNV=%b%b%b%b",
               tag(op, bm), op, bm, res_o, wr_o, flag_o, c_o, z_o, n_o, v_o, r[15:0], w, f, c, z, n, v);
    end
  endtask

  function automatic logic [15:0] rnd_bcd();
    logic [15:0] x;
    for (int i = 0; i < 4; i++) x[4*i +: 4] = 4'($urandom_range(0, 9));
    return x;
  endfunction

  initial begin
    src_i = '0; dst_i = '0; carry_i = 0; op_i = '0; byte_i = 0;
    // R7 decimal examples, word and byte
    run(16'h1238, 16'h7684, 0, 5, 0);
    run(16'h1238, 16'h7684, 0, 5, 1);
    run(16'h9999, 16'h0000, 1, 5, 0);
    // R8 rotate and shift
    run(16'h0, 16'h873B, 0, 12, 0);
    run(16'h0, 16'hFB0F, 0, 11, 0);
    run(16'h0, 16'h0081, 1, 12, 1);
    // R9 sign extend and swap, byte bit ignored
    run(16'h0, 16'hA587, 0, 13, 1);
    run(16'h0, 16'hA577, 0, 13, 0);
    run(16'h0, 16'h12F0, 0, 14, 1);
    // R5 logic examples
    run(16'h35AB, 16'hAB96, 0, 6, 0);
    run(16'h35AB, 16'hAB96, 0, 8, 1);
    run(16'h35AB, 16'hAB96, 0, 7, 0);
    run(16'h00FF, 16'hFF00, 0, 6, 0);
    // R6 set and clear bits
    run(16'h35AB, 16'hAB96, 1, 9, 0);
    run(16'h35AB, 16'hAB96, 1, 10, 1);
    // R1 R3 R4 carry, overflow and zero boundaries
    run(16'h0001, 16'hFFFF, 0, 0, 0);
    run(16'h0001, 16'h7FFF, 0, 0, 0);
    run(16'h0001, 16'h007F, 0, 0, 1);
    run(16'hFF80, 16'h0080, 1, 1, 1);
    // R2 R3 subtraction and borrow
    run(16'h0001, 16'h0000, 0, 2, 0);
    run(16'h0001, 16'h8000, 0, 2, 0);
    run(16'h0005, 16'h0005, 0, 4, 0);
    run(16'h0001, 16'h0001, 0, 3, 1);
    // R11 pass-through
    run(16'h1234, 16'hBEEF, 1, 15, 1);
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 15);
      logic [15:0] s = 16'($urandom);
      logic [15:0] d = 16'($urandom);
      if (op == 5) begin s = rnd_bcd(); d = rnd_bcd(); end
      run(s, d, 1'($urandom), op, 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired: got %0d cycles expected under 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule